// File: doc/BRIEF.md
# Local Tick Timer

This block is one core's local timer, built from two stages. A prescaler divides the system clock. It emits one tick every (tick base + 1) clock cycles, and only while the timer run bit is set. An interrupt counter 31 bits wide counts those ticks down. When the count runs out, it raises an interrupt status flag. In auto-reload mode the counter restores its committed count and fires again at the same period until software stops it. In single-shot mode it fires once and then waits for a fresh load.

Software programs the block through a small register window. A count written to the interrupt count buffer takes effect only when bit 31 of the same write is 1. Such a write commits the count and restarts the countdown. Each write to the tick base, count buffer or control register is acknowledged by a flag in a write acknowledge register. The flag appears a fixed two cycles later, and software clears it by writing 1. The interrupt output is the status flag gated by an enable bit.

Top module: `ltt_local_tick`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: While control bit 0 (run) is 1, the prescaler emits a tick every TB+1 clock cycles, where TB is the tick base at offset 0x00 (TB=0 ticks every cycle). While run is 0 no tick occurs and the countdown does not advance.
- R3: A write to offset 0x08 with bit 31 = 1 commits bits [30:0] as the reload value and loads the counter with it. A write with bit 31 = 0 changes neither the counter nor the readback. Offset 0x08 reads the committed value in bits [30:0], with bit 31 reading 0.
- R4: With control bits 0 and 1 both set and a committed count N ≥ 1, the counter decrements once per tick. Status bit 0 (offset 0x30) sets on the tick that exhausts the count. If the prescaler was idle, this happens exactly N·(TB+1) rising edges after the edge that wrote the control register.
- R5: With control bit 2 (auto-reload) = 1, the counter reloads N on expiry and expires again every N·(TB+1) cycles.
- R6: With control bit 2 = 0, the counter expires once and produces no further expiry until a new committed load.
- R7: Writing 0 to control bits 0 and 1 halts the countdown, and no further expiry occurs.
- R8: Writing 1 to bit 0 of offset 0x30 clears the status. Writing 0 leaves it unchanged. An expiry in the same cycle as a clear wins.
- R9: `irq` equals status bit 0 AND enable bit 0 (offset 0x34). A set status with enable 0 keeps `irq` low.
- R10: In the acknowledge register (offset 0x40), bit 0 marks a write to 0x00, bit 1 a write to 0x08 and bit 3 a write to 0x20. Each bit sets on the second rising edge, counting the edge that samples the write. Writing 1 to a bit clears it. Writes to 0x30, 0x34 and 0x40 set no bit.
- R11: The tick base reads back in full at 0x00, the control bits [2:0] at 0x20 and the enable bit at 0x34.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write offset within the block window |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read offset (combinational read) |
| rd_data | output | 32 | Read data for `rd_addr` |
| irq | output | 1 | Interrupt request, status AND enable |

## Verification
The assertions assume that `wr_en`, `wr_addr` and `wr_data` are stable and free of X across each rising edge. They also assume that a committed load never coincides with a write that changes the run or start bits in a way the counter must see in the same cycle. The bench drives all inputs on falling edges and issues one register write per cycle. It stops the timer before every reprogramming and clears the status before each timed wait, so every measured interval starts from an idle prescaler and a known count.

// File: rtl/ltt_pkg.sv
package ltt_pkg;
    localparam int unsigned BUS_W   = 32;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned ACK_W   = 4;
    localparam int unsigned UPD_BIT = 31;

    // register offsets inside one instance window (software decodes these)
    localparam logic [ADDR_W-1:0] OFS_TICKBUF = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CNTBUF  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_STAT    = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_IEN     = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_WACK    = 8'h40;

    // control bits
    localparam int unsigned CTRL_RUN    = 0;
    localparam int unsigned CTRL_ISTART = 1;
    localparam int unsigned CTRL_AUTO   = 2;
    localparam int unsigned CTRL_W      = 3;

    // acknowledge bit positions
    localparam int unsigned ACK_TB   = 0;
    localparam int unsigned ACK_CB   = 1;
    localparam int unsigned ACK_CTRL = 3;
endpackage

// File: rtl/ltt_prescaler.sv
module ltt_prescaler #(
    parameter int unsigned TB_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic [TB_W-1:0] limit_i,
    output logic            tick_o
);
    typedef struct packed {
        logic [TB_W-1:0] pcnt;
    } pre_st_t;

    pre_st_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        tick_o = run_i && (st_q.pcnt >= limit_i);
        if (!run_i)
            st_d.pcnt = '0;
        else if (tick_o)
            st_d.pcnt = '0;
        else
            st_d.pcnt = st_q.pcnt + TB_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // a tick is followed by a full period unless the divisor is one
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && limit_i != '0) |=> (!tick_o || limit_i == '0));

    // stopping the prescaler keeps it quiet in the next cycle too
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && limit_i != '0) |=> !tick_o);
endmodule

// File: rtl/ltt_intcnt.sv
module ltt_intcnt #(
    parameter int unsigned CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cnt_en_i,
    input  logic             auto_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expire_o,
    output logic [CNT_W-1:0] reload_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rel;
        logic             armed;
    } ic_st_t;

    ic_st_t st_q, st_d;
    logic   step;

    always_comb begin
        st_d     = st_q;
        step     = tick_i && cnt_en_i && st_q.armed;
        expire_o = step && !load_i && (st_q.cnt <= CNT_W'(1));
        if (load_i) begin
            st_d.cnt   = load_val_i;
            st_d.rel   = load_val_i;
            st_d.armed = 1'b1;
        end else if (expire_o) begin
            if (auto_i) begin
                st_d.cnt = st_q.rel;
            end else begin
                st_d.cnt   = '0;
                st_d.armed = 1'b0;
            end
        end else if (step) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        reload_o = st_q.rel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // halted counter holds its value (R7)
    assert_hold_when_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en_i && !load_i) |=> $stable(st_q.cnt));

    // live count never exceeds the committed reload (R3)
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.rel);
endmodule

// File: rtl/ltt_wack.sv
module ltt_wack #(
    parameter int unsigned ACK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACK_W-1:0] hit_i,
    input  logic [ACK_W-1:0] clr_i,
    output logic [ACK_W-1:0] stat_o
);
    typedef struct packed {
        logic [ACK_W-1:0] pend;
        logic [ACK_W-1:0] stat;
    } ack_st_t;

    ack_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.pend = hit_i;
        st_d.stat = (st_q.stat & ~clr_i) | st_q.pend;
        stat_o    = st_q.stat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < ACK_W; i++) begin : g_chk
        // an acknowledge appears only two cycles after its write (R10)
        assert_ack_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat_o[i]) |-> $past(hit_i[i], 2));
    end
endmodule

// File: rtl/ltt_local_tick.sv
module ltt_local_tick
    import ltt_pkg::*;
#(
    parameter int unsigned TB_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BUS_W-1:0]  rd_data,
    output logic              irq
);
    localparam int unsigned CNT_W = BUS_W - 1;

    typedef struct packed {
        logic [TB_W-1:0]   tbuf;
        logic [CTRL_W-1:0] ctrl;
        logic              stat;
        logic              ien;
    } top_st_t;

    top_st_t st_q, st_d;

    logic             wr_tb, wr_cb, wr_ctrl, wr_stat, wr_ien, wr_wack;
    logic             tick, expire, load;
    logic [CNT_W-1:0] reload;
    logic [ACK_W-1:0] ack_hit, ack_clr, ack_stat;

    always_comb begin
        wr_tb   = wr_en && (wr_addr == OFS_TICKBUF);
        wr_cb   = wr_en && (wr_addr == OFS_CNTBUF);
        wr_ctrl = wr_en && (wr_addr == OFS_CTRL);
        wr_stat = wr_en && (wr_addr == OFS_STAT);
        wr_ien  = wr_en && (wr_addr == OFS_IEN);
        wr_wack = wr_en && (wr_addr == OFS_WACK);
        load    = wr_cb && wr_data[UPD_BIT];

        ack_hit           = '0;
        ack_hit[ACK_TB]   = wr_tb;
        ack_hit[ACK_CB]   = wr_cb;
        ack_hit[ACK_CTRL] = wr_ctrl;
        ack_clr           = wr_wack ? wr_data[ACK_W-1:0] : '0;
    end

    ltt_prescaler #(.TB_W(TB_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (st_q.ctrl[CTRL_RUN]),
        .limit_i (st_q.tbuf),
        .tick_o  (tick)
    );

    ltt_intcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .cnt_en_i   (st_q.ctrl[CTRL_ISTART]),
        .auto_i     (st_q.ctrl[CTRL_AUTO]),
        .load_i     (load),
        .load_val_i (wr_data[CNT_W-1:0]),
        .expire_o   (expire),
        .reload_o   (reload)
    );

    ltt_wack #(.ACK_W(ACK_W)) u_ack (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (ack_hit),
        .clr_i  (ack_clr),
        .stat_o (ack_stat)
    );

    always_comb begin
        st_d = st_q;
        if (wr_tb)   st_d.tbuf = wr_data[TB_W-1:0];
        if (wr_ctrl) st_d.ctrl = wr_data[CTRL_W-1:0];
        if (wr_ien)  st_d.ien  = wr_data[0];
        st_d.stat = expire || (st_q.stat && !(wr_stat && wr_data[0]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            OFS_TICKBUF: rd_data = BUS_W'(st_q.tbuf);
            OFS_CNTBUF:  rd_data = BUS_W'(reload);
            OFS_CTRL:    rd_data = BUS_W'(st_q.ctrl);
            OFS_STAT:    rd_data = BUS_W'(st_q.stat);
            OFS_IEN:     rd_data = BUS_W'(st_q.ien);
            OFS_WACK:    rd_data = BUS_W'(ack_stat);
            default:     rd_data = '0;
        endcase
        irq = st_q.stat && st_q.ien;
    end

    // status only rises as a result of a prescaler tick (R4)
    assert_stat_from_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.stat) |-> $past(tick));

    // a clear write with no expiry leaves the status low (R8)
    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wr_data[0] && !tick) |=> !st_q.stat);
endmodule

// File: tb/tb_ltt_local_tick.sv
`timescale 1ns/1ps
module tb_ltt_local_tick;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int t0    = 0;
    bit done  = 1'b0;

    localparam logic [7:0] A_TB = 8'h00, A_CB = 8'h08, A_CT = 8'h20,
                           A_ST = 8'h30, A_IE = 8'h34, A_WA = 8'h40;

    ltt_local_tick dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the write edge
    task automatic wr(logic [7:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output int v);
        rd_addr = a;
        #0.5;
        v = int'(rd_data);
    endtask

    task automatic wait_irq(int lim, output int at);
        at = -1;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (irq) begin at = cyc; break; end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic setup(int tb, int n, int ctrl);
        wr(A_CT, 0);
        wr(A_ST, 1);
        wr(A_TB, tb);
        wr(A_CB, 32'h8000_0000 | n);
        wr(A_IE, 1);
        wr(A_CT, ctrl);
        t0 = cyc;
    endtask

    task automatic t_reset;
        int v;
        rd(A_TB, v); chk("R1 tickbase", v, 0);
        rd(A_CB, v); chk("R1 countbuf", v, 0);
        rd(A_CT, v); chk("R1 ctrl", v, 0);
        rd(A_ST, v); chk("R1 status", v, 0);
        rd(A_IE, v); chk("R1 enable", v, 0);
        rd(A_WA, v); chk("R1 wack", v, 0);
        chk("R1 irq", int'(irq), 0);
    endtask

    task automatic t_wack;
        int v;
        wr(A_TB, 9);
        rd(A_WA, v); chk("R10 not yet", v, 0);
        @(negedge clk);
        rd(A_WA, v); chk("R10 tb ack", v, 1);
        wr(A_WA, 1);
        rd(A_WA, v); chk("R10 w1c", v, 0);
        wr(A_CB, 7);
        idle(1);
        rd(A_WA, v); chk("R10 cb ack", v, 2);
        wr(A_WA, 2);
        wr(A_CT, 0);
        idle(1);
        rd(A_WA, v); chk("R10 ctrl ack", v, 8);
        wr(A_WA, 32'hF);
        wr(A_IE, 0);
        wr(A_ST, 0);
        idle(3);
        rd(A_WA, v); chk("R10 other offsets", v, 0);
        rd(A_TB, v); chk("R11 tickbase readback", v, 9);
    endtask

    task automatic t_oneshot;
        int at, v;
        setup(3, 5, 3);
        wait_irq(100, at);
        chk("R4 first expiry", at - t0, 20);
        wr(A_ST, 1);
        idle(80);
        chk("R6 no second irq", int'(irq), 0);
        rd(A_ST, v); chk("R6 status stays clear", v, 0);
        rd(A_CB, v); chk("R3 readback", v, 5);
    endtask

    task automatic t_interval;
        int a1, a2, a3, v;
        setup(2, 4, 7);
        rd(A_CT, v); chk("R11 ctrl readback", v, 7);
        rd(A_IE, v); chk("R11 enable readback", v, 1);
        wait_irq(100, a1);
        chk("R5 first", a1 - t0, 12);
        wr(A_ST, 1);
        rd(A_ST, v); chk("R8 cleared", v, 0);
        wait_irq(100, a2);
        chk("R5 second period", a2 - a1, 12);
        wr(A_ST, 1);
        wait_irq(100, a3);
        chk("R5 third period", a3 - a2, 12);
    endtask

    task automatic t_fast;
        int a1, a2;
        setup(0, 3, 7);
        wait_irq(50, a1);
        chk("R2 base zero", a1 - t0, 3);
        wr(A_ST, 1);
        wait_irq(50, a2);
        chk("R2 base zero period", a2 - a1, 3);
    endtask

    task automatic t_run_gate;
        int at;
        setup(1, 6, 2);
        idle(60);
        chk("R2 no tick without run", int'(irq), 0);
        wr(A_CT, 7);
        t0 = cyc;
        wait_irq(100, at);
        chk("R2 resume timing", at - t0, 12);
    endtask

    task automatic t_stop;
        int at, v;
        setup(1, 6, 7);
        wait_irq(100, at);
        wr(A_ST, 1);
        wr(A_CT, 0);
        idle(60);
        chk("R7 stopped irq", int'(irq), 0);
        rd(A_ST, v); chk("R7 stopped status", v, 0);
    endtask

    task automatic t_update_ignore;
        int a1, a2, v;
        setup(1, 5, 7);
        wait_irq(100, a1);
        wr(A_CB, 3);
        wr(A_ST, 1);
        wait_irq(100, a2);
        chk("R3 unflagged write ignored", a2 - a1, 10);
        rd(A_CB, v); chk("R3 readback kept", v, 5);
    endtask

    task automatic t_mask_w1c;
        int v;
        setup(3, 5, 3);
        wr(A_IE, 0);
        idle(40);
        chk("R9 masked irq", int'(irq), 0);
        rd(A_ST, v); chk("R4 status set while masked", v, 1);
        wr(A_IE, 1);
        chk("R9 unmasked irq", int'(irq), 1);
        wr(A_ST, 0);
        rd(A_ST, v); chk("R8 write zero keeps", v, 1);
        wr(A_ST, 1);
        rd(A_ST, v); chk("R8 write one clears", v, 0);
        chk("R9 irq after clear", int'(irq), 0);
    endtask

    initial begin
        #20000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wack();
        t_oneshot();
        t_interval();
        t_fast();
        t_run_gate();
        t_stop();
        t_update_ignore();
        t_mask_w1c();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule